// File: doc/BRIEF.md
# SPI Serial Clock Rate Generator

This block derives the serial clock timing of an SPI master from the system clock. Two dividers are chained. The first is an even prescaler `presc`. The second divides its output by one plus the value `div`. One full serial bit therefore lasts `presc * (1 + div)` system clocks. The output rate runs from half the system clock (prescale 2, divide 0) down to 1/(254*256) of it (prescale 254, divide 255).

The generator emits a one-cycle `tick` strobe at every half bit period, which is where the serial clock changes level. It also drives `sclk`, which rests at the level chosen by `cpol` while the generator is stopped and inverts at each strobe while it runs.

Prescale and divide values are sampled only at bit boundaries, so a bit already in progress always completes with the settings it started with. Dropping `en` clears all counting state. Raising it again starts a fresh bit from the beginning. Frame control, data shifting and register access live elsewhere.

Top module: `spi_rate_gen`

## Requirements
- R1: While `rst` is high, `tick` stays 0 and `sclk` equals `cpol`, whatever the value of `en`.
- R2: While `en` is low, `tick` stays 0 and `sclk` equals `cpol`.
- R3: With prescale P (effective, even) and divide D, let H = (P/2)*(1+D). Counting the first cycle in which `en` is high as cycle 1, `tick` is high exactly in cycles H, 2H, 3H and so on.
- R4: `sclk` inverts after every `tick`. It leaves its idle level after the first tick of a bit and returns to the idle level after the second, so one full `sclk` period spans P*(1+D) clocks.
- R5: Bit 0 of `presc` is ignored: an odd value behaves as the next lower even value (7 acts as 6, 255 acts as 254).
- R6: A `presc` value of 0 or 1 behaves as 2.
- R7: With P = 2 and D = 0, `tick` is high in every enabled cycle and `sclk` alternates every cycle (half the system clock rate).
- R8: With P = 254 and D = 255, the first tick arrives 32512 cycles after enable.
- R9: A change of `presc` or `div` while enabled takes effect only after the tick that ends the current bit (the second tick of the bit). The bit in progress keeps its old half period.
- R10: Lowering `en` in the middle of a bit and raising it again restarts timing: the first tick comes H cycles after the re-enable, and `sclk` starts from the idle level.
- R11: The idle level of `sclk` follows `cpol` (0 gives idle low, 1 gives idle high). After the first tick of a bit, `sclk` equals the inverse of `cpol`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low holds and clears all counting |
| cpol | input | 1 | Idle level of the serial clock |
| presc | input | 8 | Prescale value; even, with the LSB ignored and a minimum of 2 |
| div | input | 8 | Second-stage divide value; the divide ratio is 1 + div |
| tick | output | 1 | One-cycle strobe at each half bit period |
| sclk | output | 1 | Serial clock level |

## Verification
The bench targets prescale values of 0, 1 and odd numbers. A design that kept the LSB, or that did not clamp the minimum, would show a half period that is off by a factor or stuck. It runs the fastest setting, where a design with an extra register stage would miss the every-cycle strobe, and the slowest setting, where a narrow counter would wrap early. It changes the settings between the two halves of a bit, which catches a design that reloads mid-bit and produces a short half period. It also drops `en` mid-bit, which catches leftover count or phase state that would shorten the first tick or start `sclk` at the wrong level.

// File: rtl/spi_rate_pkg.sv
package spi_rate_pkg;

    parameter int PRESC_W = 8;
    parameter int DIV_W   = 8;
    localparam int HALF_W = PRESC_W - 1;

    typedef struct packed {
        logic [HALF_W-1:0] half;  // prescale / 2, never zero
        logic [DIV_W-1:0]  div;   // second-stage terminal count
    } rate_cfg_t;

    typedef enum logic {
        PH_LEAD  = 1'b0,
        PH_TRAIL = 1'b1
    } half_phase_e;

    // Drop the prescale LSB and clamp to the minimum even value of 2.
    function automatic rate_cfg_t make_cfg(input logic [PRESC_W-1:0] presc,
                                           input logic [DIV_W-1:0]   div);
        rate_cfg_t c;
        c.half = HALF_W'(presc >> 1);
        if (c.half == '0)
            c.half = HALF_W'(1);
        c.div = div;
        return c;
    endfunction

endpackage

// File: rtl/rate_cfg_hold.sv
module rate_cfg_hold
    import spi_rate_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [PRESC_W-1:0] presc,
    input  logic [DIV_W-1:0]   div,
    output rate_cfg_t          cfg
);

    always_ff @(posedge clk) begin
        if (rst || load)
            cfg <= make_cfg(presc, div);
    end

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> cfg == $past(cfg));

    // R6
    half_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        cfg.half != '0);

endmodule

// File: rtl/rate_prescaler.sv
module rate_prescaler
    import spi_rate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    output logic              pre_tick
);

    logic [HALF_W-1:0] cnt;

    assign pre_tick = run && (cnt == half - HALF_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (pre_tick)
            cnt <= '0;
        else
            cnt <= cnt + HALF_W'(1);
    end

    // R3
    presc_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < half);

    // R2
    presc_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt == '0);

endmodule

// File: rtl/rate_divider.sv
module rate_divider
    import spi_rate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             pre_tick,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic             at_end;

    assign at_end = (cnt == div);
    assign tick   = pre_tick && at_end;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (pre_tick)
            cnt <= at_end ? '0 : cnt + DIV_W'(1);
    end

    // R3
    div_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= div);

    // R10
    div_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt == '0);

endmodule

// File: rtl/rate_phase.sv
module rate_phase
    import spi_rate_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        run,
    input  logic        tick,
    output half_phase_e ph,
    output logic        bit_end
);

    assign bit_end = tick && (ph == PH_TRAIL);

    always_ff @(posedge clk) begin
        if (rst || !run)
            ph <= PH_LEAD;
        else if (tick)
            ph <= (ph == PH_LEAD) ? PH_TRAIL : PH_LEAD;
    end

    // R4
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        run && !tick |=> ph == $past(ph));

endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
    import spi_rate_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               cpol,
    input  logic [PRESC_W-1:0] presc,
    input  logic [DIV_W-1:0]   div,
    output logic               tick,
    output logic               sclk
);

    logic        run;
    logic        load;
    logic        pre_tick;
    logic        bit_end;
    rate_cfg_t   cfg;
    half_phase_e ph;

    assign run  = en && !rst;
    assign load = !run || bit_end;

    rate_cfg_hold u_cfg (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .presc (presc),
        .div   (div),
        .cfg   (cfg)
    );

    rate_prescaler u_pre (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .half     (cfg.half),
        .pre_tick (pre_tick)
    );

    rate_divider u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .pre_tick (pre_tick),
        .div      (cfg.div),
        .tick     (tick)
    );

    rate_phase u_ph (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .tick    (tick),
        .ph      (ph),
        .bit_end (bit_end)
    );

    assign sclk = cpol ^ (ph == PH_TRAIL);

    // R2
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> sclk == cpol);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |-> !tick);

endmodule

// File: tb/tb_spi_rate_gen.sv
module tb_spi_rate_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       cpol = 1'b0;
    logic [7:0] presc = 8'd2;
    logic [7:0] div = 8'd0;
    logic       tick;
    logic       sclk;

    int n_checks = 0;
    int n_fails = 0;

    always #5 clk = ~clk;

    spi_rate_gen dut (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .cpol  (cpol),
        .presc (presc),
        .div   (div),
        .tick  (tick),
        .sclk  (sclk)
    );

    // presc, div, cpol, expected half period (cycles)
    localparam int NV = 9;
    localparam int V_P [NV] = '{2, 4, 6, 7, 1, 0, 10, 64, 255};
    localparam int V_D [NV] = '{0, 0, 2, 1, 3, 0, 4, 0, 1};
    localparam int V_C [NV] = '{0, 1, 0, 1, 0, 1, 0, 1, 0};
    localparam int V_H [NV] = '{1, 2, 9, 6, 4, 1, 25, 32, 254};

    task automatic check(input int act, input int exp, input string req);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count cycles up to and including the one with tick high.
    task automatic measure(output int n, input int limit);
        n = 0;
        forever begin
            #1;
            n++;
            if (tick) break;
            if (n >= limit) break;
            @(negedge clk);
        end
    endtask

    task automatic step;
        @(negedge clk);
        #1;
    endtask

    initial begin
        #1_500_000;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        int n;
        // R1: reset holds quiet even with en high and fastest setting
        rst = 1'b1; en = 1'b1; cpol = 1'b1; presc = 8'd2; div = 8'd0;
        repeat (3) step();
        check(int'(tick), 0, "R1 tick in reset");
        check(int'(sclk), 1, "R1 sclk in reset");
        rst = 1'b0; en = 1'b0;
        repeat (2) step();
        check(int'(tick), 0, "R2 tick disabled");
        check(int'(sclk), 1, "R2 sclk idle");

        // Vector table: R3 R4 R5 R6 R11
        for (int i = 0; i < NV; i++) begin
            en = 1'b0;
            presc = 8'(V_P[i]); div = 8'(V_D[i]); cpol = 1'(V_C[i]);
            repeat (2) step();
            check(int'(sclk), V_C[i], $sformatf("R11 idle v%0d", i));
            en = 1'b1;
            measure(n, 1000);
            check(n, V_H[i], $sformatf("R3 R5 R6 first tick v%0d", i));
            step();
            check(int'(sclk), 1 - V_C[i], $sformatf("R4 sclk after tick1 v%0d", i));
            measure(n, 1000);
            check(n, V_H[i], $sformatf("R3 second tick v%0d", i));
            step();
            check(int'(sclk), V_C[i], $sformatf("R4 sclk after tick2 v%0d", i));
            en = 1'b0;
            step();
        end

        // R7: fastest rate, tick every cycle, sclk alternates
        en = 1'b0; presc = 8'd2; div = 8'd0; cpol = 1'b0;
        repeat (2) step();
        en = 1'b1;
        for (int k = 0; k < 6; k++) begin
            #1;
            check(int'(tick), 1, "R7 tick every cycle");
            check(int'(sclk), k % 2, "R7 sclk alternates");
            step();
        end
        en = 1'b0; step();

        // R9: change settings mid-bit
        presc = 8'd4; div = 8'd1; cpol = 1'b0;
        repeat (2) step();
        en = 1'b1;
        measure(n, 100);
        check(n, 4, "R9 first tick old setting");
        presc = 8'd2; div = 8'd0;
        step();
        measure(n, 100);
        check(n, 4, "R9 second half keeps old setting");
        step();
        measure(n, 100);
        check(n, 1, "R9 new setting after bit end");
        en = 1'b0; step();

        // R10: abort mid-bit and restart
        presc = 8'd4; div = 8'd1; cpol = 1'b1;
        repeat (2) step();
        en = 1'b1;
        measure(n, 100);
        step();
        step();
        en = 1'b0;
        step();
        check(int'(tick), 0, "R10 no tick after disable");
        check(int'(sclk), 1, "R10 sclk back to idle");
        step();
        en = 1'b1;
        measure(n, 100);
        check(n, 4, "R10 restart full half period");
        step();
        check(int'(sclk), 0, "R10 sclk leaves idle after restart");
        en = 1'b0; step();

        // R8: slowest rate
        presc = 8'd254; div = 8'd255; cpol = 1'b0;
        repeat (2) step();
        en = 1'b1;
        measure(n, 40000);
        check(n, 32512, "R8 slowest half period");
        step();
        check(int'(sclk), 1, "R8 sclk toggled");
        en = 1'b0; step();

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule